// File: doc/BRIEF.md
# Live PLL Frequency Crawl Sequencer

This block moves a running clock PLL to a new VCO frequency without switching the PLL off. A requester presents the present clock setting (VCO, output clock, reference) and the wanted setting, together with a feature-enable level, and pulses `start`. The sequencer decides whether a crawl is allowed. A crawl needs both VCOs to be nonzero and different, the same reference, and the same rounded VCO-to-output divider on both sides, so the post-divider never changes.

When a crawl is allowed, the sequencer computes the new feedback ratio with rounded iterative dividers. It then issues three writes to the PLL control word. The first carries the new ratio with the enable kept high. The second adds the frequency-change request. The third drops the request again, after the PLL reports both lock and acknowledge or after a fixed timeout of 200 microseconds counted in core clocks. At the end the target VCO is recorded and a one-cycle `done` pulse is given, with `err` marking a timeout.

A setting that cannot be crawled is refused without touching the PLL, and `not_elig` is raised. A request for the VCO already running (feature on, both nonzero) finishes with no write at all.

Top module: `pll_crawl_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy`, `done`, `err`, `not_elig` and `reg_wr` are 0, and `reg_wdata` and `vco_rec_khz` are 0.
- R2: `start` is accepted only when the block is idle. The settings are captured at the accepting edge, and a `start` seen while busy has no effect. `busy` is high from the cycle after acceptance until the cycle in which `done` is pulsed.
- R3: A crawl proceeds only if `crawl_en` is 1, both VCOs are nonzero, they differ, the references are equal, and round(VCO/clock) is equal for the old and new setting. A divide by a zero clock yields all ones. Otherwise (and outside the R4 case) the block pulses `done`, sets `not_elig` and issues no write.
- R4: With `crawl_en` at 1 and both VCOs nonzero and equal, the block pulses `done` with `not_elig` and `err` at 0. It issues no write, and `vco_rec_khz` takes the new VCO.
- R5: The ratio is round(new VCO / new reference), rounding halves upward. Its low 8 bits go to write-data bits [7:0].
- R6: The first write strobe is high in the cycle after the edge FREQ_W+2 clocks past the accepting edge. It carries bit 31 (enable) = 1, bit 23 (request) = 0, the ratio in [7:0], and all other bits 0.
- R7: In the next cycle a second strobe writes the same word with bit 23 set.
- R8: Acknowledge is taken only when status bit 30 (lock) and bit 22 (ack) are both 1 at a clock edge during the wait. At that edge the clearing write is issued, with `err` at 0.
- R9: If lock and ack are not both 1 at any of the TMO edges that follow the edge raising the request strobe, the clearing write is issued at the last of them and `err` is set. TMO = CLK_HZ/1e6 × TIMEOUT_US (25000 at defaults).
- R10: The clearing write keeps the ratio and bit 31 and clears bit 23. `done` pulses in the same cycle, and `vco_rec_khz` takes the new VCO on success and on timeout alike.
- R11: `done` is a one-cycle pulse. `err` and `not_elig` hold their value until the next accepted `start` clears them.
- R12: `reg_wdata` does not change in any cycle in which `reg_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (idle only) |
| crawl_en | input | 1 | Crawl feature present |
| old_vco_khz | input | FREQ_W | Running VCO in kHz |
| old_clk_khz | input | FREQ_W | Running output clock in kHz |
| old_ref_khz | input | FREQ_W | Running reference in kHz |
| new_vco_khz | input | FREQ_W | Target VCO in kHz |
| new_clk_khz | input | FREQ_W | Target output clock in kHz |
| new_ref_khz | input | FREQ_W | Target reference in kHz |
| reg_status | input | 32 | Readable PLL control/status word |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 32 | Write data, held between strobes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Handshake timed out |
| not_elig | output | 1 | Request refused, PLL untouched |
| vco_rec_khz | output | FREQ_W | Recorded current VCO |

## Verification
The bench drives the acknowledge at the last edge that still counts and at the first edge past the window. A timer off by one would pass or fail the wrong one of these. It rounds ratios exactly at and just below a half, and feeds a ratio above 255. A divider rounding the wrong way or not truncating would put a wrong value in bits [7:0]. It raises ack while lock stays low, so a design watching ack alone would report success where the bench expects a timeout. It pulses `start` again while busy, and it presents equal VCOs, changed dividers, differing references and zero VCOs. A design that restarted, or that wrote the PLL for a refused or unchanged setting, would show stray strobes or a wrong flag against the cycle-by-cycle model.

// File: rtl/pll_crawl_pkg.sv
package pll_crawl_pkg;

  localparam int RATIO_W  = 8;
  localparam int EN_BIT   = 31;
  localparam int LOCK_BIT = 30;
  localparam int REQ_BIT  = 23;
  localparam int ACK_BIT  = 22;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_REQ,
    ST_WAIT
  } crawl_st_t;

  // Control word: ratio in the low field, enable always kept high
  function automatic logic [31:0] ctl_word(input logic [RATIO_W-1:0] ratio,
                                           input logic req);
    logic [31:0] w;
    w = '0;
    w[RATIO_W-1:0] = ratio;
    w[EN_BIT]      = 1'b1;
    w[REQ_BIT]     = req;
    return w;
  endfunction

endpackage

// File: rtl/pll_crawl_rdiv.sv
// Restoring divider, one quotient bit per clock. Numerator is sampled at
// go; denominator must stay stable for the following NW cycles.
module pll_crawl_rdiv #(
  parameter int NW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          vld
);

  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_r;
  logic [NW-1:0] r_r;
  logic [CW-1:0] cnt;
  logic [NW:0]   trial;
  logic [NW:0]   diff;

  assign trial = {r_r, q_r[NW-1]};
  assign diff  = trial - {1'b0, den};
  assign quo   = q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0;
      r_r <= '0;
      cnt <= '0;
      vld <= 1'b0;
    end else if (go) begin
      q_r <= num;
      r_r <= '0;
      cnt <= CW'(NW);
      vld <= 1'b0;
    end else if (cnt != '0) begin
      if (!diff[NW]) begin
        r_r <= diff[NW-1:0];
        q_r <= {q_r[NW-2:0], 1'b1};
      end else begin
        r_r <= trial[NW-1:0];
        q_r <= {q_r[NW-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) vld <= 1'b1;
    end
  end

endmodule

// File: rtl/pll_crawl_ctl.sv
module pll_crawl_ctl
  import pll_crawl_pkg::*;
#(
  parameter int FREQ_W  = 24,
  parameter int TMO_CYC = 25000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               div_vld,
  input  logic               can_crawl,
  input  logic               no_change,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [FREQ_W-1:0]  tgt_vco,
  input  logic               pll_locked,
  input  logic               pll_acked,
  output logic               accept,
  output logic               in_wait,
  output logic               hs_ok,
  output logic               tmo_hit,
  output logic               reg_wr,
  output logic [31:0]        reg_wdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               not_elig,
  output logic [FREQ_W-1:0]  vco_rec
);

  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  crawl_st_t     st;
  logic [TW-1:0] tmr;

  assign accept  = start && (st == ST_IDLE);
  assign busy    = (st != ST_IDLE);
  assign in_wait = (st == ST_WAIT);
  assign hs_ok   = in_wait && pll_locked && pll_acked;
  assign tmo_hit = in_wait && (tmr == TMO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      not_elig  <= 1'b0;
      vco_rec   <= '0;
    end else begin
      reg_wr <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st       <= ST_CALC;
            err      <= 1'b0;
            not_elig <= 1'b0;
          end
        end
        ST_CALC: begin
          if (div_vld) begin
            if (no_change) begin
              done    <= 1'b1;
              vco_rec <= tgt_vco;
              st      <= ST_IDLE;
            end else if (!can_crawl) begin
              done     <= 1'b1;
              not_elig <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              reg_wr    <= 1'b1;
              reg_wdata <= ctl_word(ratio, 1'b0);
              st        <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          reg_wr    <= 1'b1;
          reg_wdata <= ctl_word(ratio, 1'b1);
          tmr       <= '0;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (hs_ok || tmo_hit) begin
            reg_wr    <= 1'b1;
            reg_wdata <= ctl_word(ratio, 1'b0);
            done      <= 1'b1;
            err       <= !hs_ok;
            vco_rec   <= tgt_vco;
            st        <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_crawl_seq.sv
module pll_crawl_seq
  import pll_crawl_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TIMEOUT_US = 200,
  parameter int FREQ_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              crawl_en,
  input  logic [FREQ_W-1:0] old_vco_khz,
  input  logic [FREQ_W-1:0] old_clk_khz,
  input  logic [FREQ_W-1:0] old_ref_khz,
  input  logic [FREQ_W-1:0] new_vco_khz,
  input  logic [FREQ_W-1:0] new_clk_khz,
  input  logic [FREQ_W-1:0] new_ref_khz,
  input  logic [31:0]       reg_status,
  output logic              reg_wr,
  output logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              not_elig,
  output logic [FREQ_W-1:0] vco_rec_khz
);

  localparam int NW      = FREQ_W + 1;
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int NDIV    = 3;   // 0: ratio, 1: old divider, 2: new divider

  // Numerator for round-to-nearest (halves up): n + floor(d/2)
  function automatic logic [NW-1:0] rnd_num(input logic [FREQ_W-1:0] n,
                                            input logic [FREQ_W-1:0] d);
    return {1'b0, n} + {2'b0, d[FREQ_W-1:1]};
  endfunction

  function automatic logic crawl_allowed(input logic en,
                                         input logic [FREQ_W-1:0] ov,
                                         input logic [FREQ_W-1:0] nv,
                                         input logic [FREQ_W-1:0] oref,
                                         input logic [FREQ_W-1:0] nref,
                                         input logic [NW-1:0] odiv,
                                         input logic [NW-1:0] ndiv);
    return en && (ov != '0) && (nv != '0) && (ov != nv) &&
           (oref == nref) && (odiv == ndiv);
  endfunction

  function automatic logic same_vco(input logic en,
                                    input logic [FREQ_W-1:0] ov,
                                    input logic [FREQ_W-1:0] nv);
    return en && (ov != '0) && (nv != '0) && (ov == nv);
  endfunction

  // Captured settings
  logic              c_en;
  logic [FREQ_W-1:0] c_ov, c_oc, c_or, c_nv, c_nc, c_nr;

  logic accept, in_wait, hs_ok, tmo_hit;
  logic can_crawl, no_change, div_vld;

  logic [NW-1:0] dv_num [NDIV];
  logic [NW-1:0] dv_den [NDIV];
  logic [NW-1:0] dv_q   [NDIV];
  logic [NDIV-1:0] dv_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_en <= 1'b0;
      c_ov <= '0; c_oc <= '0; c_or <= '0;
      c_nv <= '0; c_nc <= '0; c_nr <= '0;
    end else if (accept) begin
      c_en <= crawl_en;
      c_ov <= old_vco_khz; c_oc <= old_clk_khz; c_or <= old_ref_khz;
      c_nv <= new_vco_khz; c_nc <= new_clk_khz; c_nr <= new_ref_khz;
    end
  end

  // Numerators come straight from the ports (loaded at the accepting edge);
  // denominators come from the captured copies used on later edges.
  always_comb begin
    dv_num[0] = rnd_num(new_vco_khz, new_ref_khz);
    dv_den[0] = {1'b0, c_nr};
    dv_num[1] = rnd_num(old_vco_khz, old_clk_khz);
    dv_den[1] = {1'b0, c_oc};
    dv_num[2] = rnd_num(new_vco_khz, new_clk_khz);
    dv_den[2] = {1'b0, c_nc};
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    pll_crawl_rdiv #(.NW(NW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (accept),
      .num  (dv_num[g]),
      .den  (dv_den[g]),
      .quo  (dv_q[g]),
      .vld  (dv_vld[g])
    );
  end

  assign div_vld   = &dv_vld;
  assign can_crawl = crawl_allowed(c_en, c_ov, c_nv, c_or, c_nr, dv_q[1], dv_q[2]);
  assign no_change = same_vco(c_en, c_ov, c_nv);

  pll_crawl_ctl #(.FREQ_W(FREQ_W), .TMO_CYC(TMO_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .div_vld   (div_vld),
    .can_crawl (can_crawl),
    .no_change (no_change),
    .ratio     (dv_q[0][RATIO_W-1:0]),
    .tgt_vco   (c_nv),
    .pll_locked(reg_status[LOCK_BIT]),
    .pll_acked (reg_status[ACK_BIT]),
    .accept    (accept),
    .in_wait   (in_wait),
    .hs_ok     (hs_ok),
    .tmo_hit   (tmo_hit),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .not_elig  (not_elig),
    .vco_rec   (vco_rec_khz)
  );

endmodule

// File: rtl/pll_crawl_seq_chk.sv
module pll_crawl_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        not_elig,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        hs_ok,
  input logic        tmo_hit
);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3/R4: a refused request finishes without a write strobe
  a_r3_refuse_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && not_elig) |-> !reg_wr);

  // R6: the PLL enable bit is never written low
  a_r6_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_wdata[31]);

  // R7: a ratio write is followed by the request write with the same ratio
  a_r7_request_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[23] && !done) |=>
      (reg_wr && reg_wdata[23] && reg_wdata[7:0] == $past(reg_wdata[7:0])));

  // R8: both lock and acknowledge end the wait with a clearing write
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ok |=> (reg_wr && !reg_wdata[23] && done && !err));

  // R9: an expired window flags the error
  a_r9_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !hs_ok) |=> (done && err && reg_wr));

  // R12: write data is held between strobes
  a_r12_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> $stable(reg_wdata));

  // R2: busy only rises after a start request
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

bind pll_crawl_seq pll_crawl_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .not_elig (not_elig),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .hs_ok    (hs_ok),
  .tmo_hit  (tmo_hit)
);

// File: tb/pll_crawl_seq_test.sv
module pll_crawl_seq_test;

  localparam int FW  = 24;
  localparam int TMO = (125_000_000 / 1_000_000) * 200;
  localparam int LAT = FW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic feat = 1'b0;
  logic [FW-1:0] ov = '0, oc = '0, orf = '0, nv = '0, nc = '0, nrf = '0;
  logic [31:0] reg_status;
  wire         reg_wr, busy, done, err, not_elig;
  wire  [31:0] reg_wdata;
  wire  [FW-1:0] vco_rec;

  always #4 clk = ~clk;

  pll_crawl_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .crawl_en(feat),
    .old_vco_khz(ov), .old_clk_khz(oc), .old_ref_khz(orf),
    .new_vco_khz(nv), .new_clk_khz(nc), .new_ref_khz(nrf),
    .reg_status(reg_status), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .err(err), .not_elig(not_elig),
    .vco_rec_khz(vco_rec)
  );

  // Behavioural PLL: ack appears dly edges after the request strobe is seen
  int   dly = 1;
  logic lock_on = 1'b1;
  logic armed;
  int   age;
  always @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; age <= 0;
    end else if (reg_wr && reg_wdata[23]) begin
      armed <= 1'b1; age <= 1;
    end else if (reg_wr) begin
      armed <= 1'b0; age <= 0;
    end else if (armed) begin
      age <= age + 1;
    end
  end
  assign reg_status = {1'b0, lock_on, 7'b0, (armed && age >= dly), 22'b0};

  // Write log
  logic [31:0] wlog [4];
  int wn;
  always @(posedge clk) begin
    if (!rst_n || (start && !busy)) wn <= 0;
    else if (reg_wr) begin
      if (wn < 4) wlog[wn] <= reg_wdata;
      wn <= wn + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic longint rdiv(input longint n, input longint d);
    if (d == 0) return (longint'(1) << 25) - 1;
    return (n + d / 2) / d;
  endfunction

  // Reference model, advanced on every clock
  int m_st, m_cnt;
  logic e_busy, e_done, e_err, e_ne, e_wr;
  logic [31:0] e_wd;
  longint e_vco;
  logic c_f;
  longint c_ov, c_oc, c_or, c_nv, c_nc, c_nr;
  bit ok_hs;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
      e_busy = 0; e_done = 0; e_err = 0; e_ne = 0; e_wr = 0; e_wd = '0; e_vco = 0;
    end else begin
      e_done = 0; e_wr = 0;
      case (m_st)
        0: if (start) begin
          c_f = feat; c_ov = ov; c_oc = oc; c_or = orf;
          c_nv = nv; c_nc = nc; c_nr = nrf;
          m_st = 1; m_cnt = 0; e_busy = 1; e_err = 0; e_ne = 0;
        end
        1: begin
          m_cnt++;
          if (m_cnt == LAT) begin
            if (c_f && c_ov != 0 && c_nv != 0 && c_ov == c_nv) begin
              e_done = 1; e_busy = 0; e_vco = c_nv; m_st = 0;
            end else if (!(c_f && c_ov != 0 && c_nv != 0 && c_or == c_nr &&
                           rdiv(c_ov, c_oc) == rdiv(c_nv, c_nc))) begin
              e_done = 1; e_ne = 1; e_busy = 0; m_st = 0;
            end else begin
              e_wr = 1;
              e_wd = 32'h8000_0000 | 32'(rdiv(c_nv, c_nr) & 255);
              m_st = 2;
            end
          end
        end
        2: begin
          e_wr = 1; e_wd = e_wd | 32'h0080_0000; m_st = 3; m_cnt = 0;
        end
        default: begin
          ok_hs = reg_status[30] && reg_status[22];
          if (ok_hs || m_cnt == TMO - 1) begin
            e_wr = 1; e_wd = e_wd & ~32'h0080_0000;
            e_done = 1; e_err = !ok_hs; e_vco = c_nv; e_busy = 0; m_st = 0;
          end else m_cnt++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == e_busy, "R2 busy", busy, e_busy);
      chk(done == e_done, "R11 done", done, e_done);
      chk(err == e_err, "R9 err", err, e_err);
      chk(not_elig == e_ne, "R3 not_elig", not_elig, e_ne);
      chk(reg_wr == e_wr, "R6 reg_wr", reg_wr, e_wr);
      chk(reg_wdata == e_wd, "R5 reg_wdata", reg_wdata, e_wd);
      chk(vco_rec == FW'(e_vco), "R10 vco_rec", vco_rec, e_vco);
    end
  end

  int cyc = 0;
  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic run(input string name, input bit f,
                     input int a_ov, input int a_oc, input int a_or,
                     input int a_nv, input int a_nc, input int a_nr,
                     input int d, input bit lk, input bit poke,
                     input int exp_w, input bit exp_err, input bit exp_ne,
                     input int exp_ratio);
    int k;
    bit seen;
    @(negedge clk);
    feat = f; ov = FW'(a_ov); oc = FW'(a_oc); orf = FW'(a_or);
    nv = FW'(a_nv); nc = FW'(a_nc); nrf = FW'(a_nr);
    dly = d; lock_on = lk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      nv = FW'(a_nv + 4800); nc = FW'(1000); start = 1'b1;   // R2: ignored
      @(negedge clk);
      start = 1'b0; nv = FW'(a_nv); nc = FW'(a_nc);
    end
    k = 0; seen = 0;
    while (k < LAT + TMO + 40) begin
      if (done) begin seen = 1; break; end
      @(negedge clk); k++;
    end
    chk(seen, {name, " R11 done seen"}, seen, 1);
    @(negedge clk);
    chk(wn == exp_w, {name, " R3/R4 write count"}, wn, exp_w);
    chk(err == exp_err, {name, " R9 err held"}, err, exp_err);
    chk(not_elig == exp_ne, {name, " R11 not_elig held"}, not_elig, exp_ne);
    if (exp_w == 3) begin
      chk(wlog[0] == (32'h8000_0000 | 32'(exp_ratio)), {name, " R6 first write"},
          wlog[0], 32'h8000_0000 | 32'(exp_ratio));
      chk(wlog[1] == (32'h8080_0000 | 32'(exp_ratio)), {name, " R7 request write"},
          wlog[1], 32'h8080_0000 | 32'(exp_ratio));
      chk(wlog[2][7:0] == 8'(exp_ratio), {name, " R5 ratio"}, wlog[2][7:0], exp_ratio);
      chk(wlog[2] == (32'h8000_0000 | 32'(exp_ratio)), {name, " R10 clearing write"},
          wlog[2], 32'h8000_0000 | 32'(exp_ratio));
      if (!exp_err) chk(!err, {name, " R8 success"}, err, 0);
      repeat (3) @(negedge clk);
      chk(reg_wdata == wlog[2], {name, " R12 hold"}, reg_wdata, wlog[2]);
    end
    if (!exp_ne) chk(vco_rec == FW'(a_nv), {name, " R10 vco recorded"}, vco_rec, a_nv);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !not_elig && !reg_wr, "R1 flags in reset",
        {busy, done, err, not_elig, reg_wr}, 0);
    chk(reg_wdata == 0 && vco_rec == 0, "R1 data in reset", reg_wdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !reg_wr && reg_wdata == 0, "R1 after reset", reg_wdata, 0);

    run("crawl",    1, 1152000, 576000, 38400, 1382400, 691200, 38400, 5, 1, 0, 3, 0, 0, 36);
    run("half_up",  1, 1152000, 576000, 38400, 1555200, 777600, 38400, 2, 1, 0, 3, 0, 0, 41);
    run("below",    1, 1152000, 576000, 38400, 1555199, 777600, 38400, 1, 1, 0, 3, 0, 0, 40);
    run("trunc",    1, 480000, 240000, 4800, 1440000, 720000, 4800, 3, 1, 0, 3, 0, 0, 44);
    run("div_chg",  1, 1152000, 576000, 38400, 1382400, 460800, 38400, 2, 1, 0, 0, 0, 1, 0);
    run("feat_off", 0, 1152000, 576000, 38400, 1382400, 691200, 38400, 2, 1, 0, 0, 0, 1, 0);
    run("ref_diff", 1, 1152000, 576000, 38400, 1382400, 691200, 19200, 2, 1, 0, 0, 0, 1, 0);
    run("old_zero", 1, 0, 576000, 38400, 1382400, 691200, 38400, 2, 1, 0, 0, 0, 1, 0);
    run("new_zero", 1, 1152000, 576000, 38400, 0, 691200, 38400, 2, 1, 0, 0, 0, 1, 0);
    run("R4 same",  1, 1382400, 691200, 38400, 1382400, 460800, 38400, 2, 1, 0, 0, 0, 0, 0);
    run("same_off", 0, 1382400, 691200, 38400, 1382400, 691200, 38400, 2, 1, 0, 0, 0, 1, 0);
    run("R2 poke",  1, 1152000, 576000, 38400, 1382400, 691200, 38400, 4, 1, 1, 3, 0, 0, 36);
    run("last_ok",  1, 1382400, 691200, 38400, 1152000, 576000, 38400, TMO - 1, 1, 0, 3, 0, 0, 30);
    run("R9 late",  1, 1152000, 576000, 38400, 1382400, 691200, 38400, TMO, 1, 0, 3, 1, 0, 36);
    run("R8 nolock",1, 1382400, 691200, 38400, 1152000, 576000, 38400, 3, 0, 0, 3, 1, 0, 30);
    run("clear",    1, 1152000, 576000, 38400, 1382400, 691200, 38400, 1, 1, 0, 3, 0, 0, 36);

    summary();
    $finish;
  end

endmodule